// File: doc/BRIEF.md
# Per-Session Packet Fair Queueing Scheduler

This block decides which packet an output link transmits next when several sessions share that link. Each session has a small queue of packet descriptors. A descriptor holds only the packet length; the payload is stored elsewhere. The block assigns each session's head packet a virtual start tag and a virtual finish tag. It also keeps one system virtual time. Whenever the link is free, it grants the head packet of one session according to a selection rule.

Two compile-time parameters choose the variant. The first is the rule that advances the system virtual time: the start tag of the served packet, the finish tag of the served packet, or a value that never decreases and is kept at least equal to the smallest head start tag. The second is the selection rule: smallest start tag, smallest finish tag, or smallest finish tag among eligible packets. The default pairs the smallest-head-start virtual time with eligible-finish selection. The reciprocal of each session's rate is a static input. The line that carries the packet out pulses `tx_done` when transmission ends.

Top module: `pfq_sched`

## Requirements
- R1: After reset, `grant_valid` is 0, `sys_vtime` is 0, and no grant appears until a packet has been enqueued.
- R2: A grant is a one-cycle pulse. It is issued only while the link is idle and at least one queue holds a packet. The link stays busy from the grant until a `tx_done` pulse. The next grant comes two cycles after that pulse at the earliest.
- R3: A head packet's finish tag equals its start tag plus (length × reciprocal rate) >> 8. The reciprocal rate is the session's 16-bit field of `recip_rate` (bits [16s+15:16s]), where 256 means one tag unit per length unit.
- R4: When a packet enters an empty session queue, its start tag is the larger of the current system virtual time and the finish tag of that session's last departed packet (0 after reset).
- R5: When a packet departs and its session still holds packets, the new head's start tag equals the departing packet's finish tag.
- R6: In the default selection, a packet is eligible when its start tag ≤ the system virtual time, and the eligible packet with the smallest finish tag is granted. If no packet is eligible, the packet with the smallest start tag is granted.
- R7: Ties between equal tags are won by the lowest session index.
- R8: In the default virtual-time mode, after every cycle the system virtual time becomes the larger of its old value and the smallest head start tag among non-empty sessions. It never decreases, and it holds its value while every queue is empty.
- R9: Each session queue keeps 16 descriptors in arrival order. An enqueue to a full queue is dropped and never granted.
- R10: With the served-start virtual time and the smallest-start selection chosen, the granted packet is the head with the smallest start tag. The system virtual time becomes that packet's start tag at the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request this cycle |
| enq_sess | input | 3 | Session index (binary) of the new packet |
| enq_len | input | 16 | Length of the new packet |
| recip_rate | input | 128 | Per-session reciprocal rate, 16 bits each, 8 fractional bits |
| tx_done | input | 1 | Current transmission finished; link becomes idle |
| grant_valid | output | 1 | One-cycle pulse: a packet is granted to the link |
| grant_sess | output | 3 | Session of the granted packet |
| grant_len | output | 16 | Length of the granted packet |
| grant_start | output | 32 | Virtual start tag of the granted packet |
| grant_finish | output | 32 | Virtual finish tag of the granted packet |
| sys_vtime | output | 32 | System virtual time |

## Verification
The hardest case to reach is one where the eligibility rule changes the order. A packet with a smaller finish tag must be passed over because its start tag lies ahead of the virtual time. That requires several sessions with packets queued at once. The bench creates this by granting a short blocking packet first. It then loads the other queues while the link is held busy, and releases the link only after every packet is queued. A second scheduler built with the alternative parameters receives the same stimulus, so the two orderings can be compared cycle for cycle.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        VT_SERVED_START   = 2'd0,
        VT_SERVED_FINISH  = 2'd1,
        VT_MIN_HEAD_START = 2'd2
    } vt_mode_e;

    typedef enum logic [1:0] {
        PICK_MIN_START       = 2'd0,
        PICK_MIN_FINISH      = 2'd1,
        PICK_ELIGIBLE_FINISH = 2'd2
    } pick_mode_e;

endpackage

// File: rtl/pfq_desc_fifo.sv
module pfq_desc_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [W-1:0]  next_head,
    output logic [CW-1:0] count,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wr = adv(st_q.wr);
        if (do_pop)  st_d.rd = adv(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

    assign head      = mem_q[st_q.rd];
    assign next_head = mem_q[adv(st_q.rd)];
    assign count     = st_q.cnt;
    assign full      = (st_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/pfq_pick.sv
module pfq_pick
    import pfq_pkg::*;
#(
    parameter int         NS   = 8,
    parameter int         TW   = 32,
    parameter pick_mode_e MODE = PICK_ELIGIBLE_FINISH,
    localparam int        SW   = $clog2(NS)
) (
    input  logic [NS-1:0]         valid,
    input  logic [NS-1:0][TW-1:0] start_tags,
    input  logic [NS-1:0][TW-1:0] finish_tags,
    input  logic [TW-1:0]         vtime,
    output logic                  found,
    output logic [SW-1:0]         pick_idx,
    output logic [TW-1:0]         min_start
);

    logic          hit_s, hit_f, hit_e;
    logic [SW-1:0] idx_s, idx_f, idx_e;
    logic [TW-1:0] best_s, best_f, best_e;

    always_comb begin
        hit_s = 1'b0; hit_f = 1'b0; hit_e = 1'b0;
        idx_s = '0;   idx_f = '0;   idx_e = '0;
        best_s = '0;  best_f = '0;  best_e = '0;
        // ascending scan with strict compare: lowest index wins ties
        for (int i = 0; i < NS; i++) begin
            if (valid[i]) begin
                if (!hit_s || start_tags[i] < best_s) begin
                    hit_s = 1'b1; best_s = start_tags[i]; idx_s = SW'(i);
                end
                if (!hit_f || finish_tags[i] < best_f) begin
                    hit_f = 1'b1; best_f = finish_tags[i]; idx_f = SW'(i);
                end
                if (start_tags[i] <= vtime && (!hit_e || finish_tags[i] < best_e)) begin
                    hit_e = 1'b1; best_e = finish_tags[i]; idx_e = SW'(i);
                end
            end
        end
        found     = hit_s;
        min_start = best_s;
        case (MODE)
            PICK_MIN_START:  pick_idx = idx_s;
            PICK_MIN_FINISH: pick_idx = idx_f;
            default:         pick_idx = hit_e ? idx_e : idx_s;
        endcase
    end

endmodule

// File: rtl/pfq_sched.sv
module pfq_sched
    import pfq_pkg::*;
#(
    parameter int         NUM_SESS = 8,
    parameter int         QDEPTH   = 16,
    parameter int         TAG_W    = 32,
    parameter int         LEN_W    = 16,
    parameter int         RECIP_W  = 16,
    parameter int         FRAC_W   = 8,
    parameter vt_mode_e   VT_MODE  = VT_MIN_HEAD_START,
    parameter pick_mode_e SEL_MODE = PICK_ELIGIBLE_FINISH,
    localparam int        SID_W    = $clog2(NUM_SESS),
    localparam int        CNT_W    = $clog2(QDEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enq_valid,
    input  logic [SID_W-1:0]            enq_sess,
    input  logic [LEN_W-1:0]            enq_len,
    input  logic [NUM_SESS*RECIP_W-1:0] recip_rate,
    input  logic                        tx_done,
    output logic                        grant_valid,
    output logic [SID_W-1:0]            grant_sess,
    output logic [LEN_W-1:0]            grant_len,
    output logic [TAG_W-1:0]            grant_start,
    output logic [TAG_W-1:0]            grant_finish,
    output logic [TAG_W-1:0]            sys_vtime
);

    typedef struct packed {
        logic [NUM_SESS-1:0][TAG_W-1:0] start;
        logic [NUM_SESS-1:0][TAG_W-1:0] finish;
        logic [TAG_W-1:0]               vt;
        logic                           busy;
        logic                           gv;
        logic [SID_W-1:0]               gs;
        logic [LEN_W-1:0]               gl;
        logic [TAG_W-1:0]               gst;
        logic [TAG_W-1:0]               gfi;
    } sched_st_t;

    sched_st_t            st_q, st_d;
    logic [NUM_SESS-1:0]  backlog, full_v, push_v, pop_v;
    logic [LEN_W-1:0]     head_len [NUM_SESS];
    logic [LEN_W-1:0]     next_len [NUM_SESS];
    logic [CNT_W-1:0]     qcnt     [NUM_SESS];
    logic                 found, grant_fire, any_backlog, link_busy;
    logic [SID_W-1:0]     pick_idx;
    logic [TAG_W-1:0]     min_start, restart_tag;
    logic [RECIP_W-1:0]   rr;

    function automatic logic [TAG_W-1:0] cost(input logic [LEN_W-1:0] len,
                                              input logic [RECIP_W-1:0] recip);
        logic [LEN_W+RECIP_W-1:0] prod;
        prod = {{RECIP_W{1'b0}}, len} * {{LEN_W{1'b0}}, recip};
        return TAG_W'(prod >> FRAC_W);
    endfunction

    function automatic logic [TAG_W-1:0] tmax(input logic [TAG_W-1:0] a,
                                              input logic [TAG_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    for (genvar g = 0; g < NUM_SESS; g++) begin : g_q
        pfq_desc_fifo #(
            .W     (LEN_W),
            .DEPTH (QDEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_v[g]),
            .push_data (enq_len),
            .pop       (pop_v[g]),
            .head      (head_len[g]),
            .next_head (next_len[g]),
            .count     (qcnt[g]),
            .full      (full_v[g])
        );
        assign backlog[g] = (qcnt[g] != '0);
    end

    pfq_pick #(
        .NS   (NUM_SESS),
        .TW   (TAG_W),
        .MODE (SEL_MODE)
    ) u_pick (
        .valid       (backlog),
        .start_tags  (st_q.start),
        .finish_tags (st_q.finish),
        .vtime       (st_q.vt),
        .found       (found),
        .pick_idx    (pick_idx),
        .min_start   (min_start)
    );

    assign any_backlog = |backlog;
    assign link_busy   = st_q.busy;
    assign grant_fire  = !st_q.busy && found;

    always_comb begin
        for (int s = 0; s < NUM_SESS; s++) begin
            push_v[s] = enq_valid && (enq_sess == SID_W'(s)) && !full_v[s];
            pop_v[s]  = grant_fire && (pick_idx == SID_W'(s));
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.gv     = 1'b0;
        restart_tag = '0;
        rr          = '0;

        // link occupancy
        if (grant_fire) begin
            st_d.busy = 1'b1;
            st_d.gv   = 1'b1;
            st_d.gs   = pick_idx;
            st_d.gl   = head_len[pick_idx];
            st_d.gst  = st_q.start[pick_idx];
            st_d.gfi  = st_q.finish[pick_idx];
        end else if (tx_done) begin
            st_d.busy = 1'b0;
        end

        // system virtual time
        case (VT_MODE)
            VT_SERVED_START:  if (grant_fire) st_d.vt = st_q.start[pick_idx];
            VT_SERVED_FINISH: if (grant_fire) st_d.vt = st_q.finish[pick_idx];
            default:          if (found)      st_d.vt = tmax(st_q.vt, min_start);
        endcase

        // per-session tags of the head packet
        for (int s = 0; s < NUM_SESS; s++) begin
            rr          = recip_rate[s*RECIP_W +: RECIP_W];
            restart_tag = tmax(st_q.vt, st_q.finish[s]);
            if (pop_v[s]) begin
                if (qcnt[s] > CNT_W'(1)) begin
                    st_d.start[s]  = st_q.finish[s];
                    st_d.finish[s] = st_q.finish[s] + cost(next_len[s], rr);
                end else if (push_v[s]) begin
                    st_d.start[s]  = restart_tag;
                    st_d.finish[s] = restart_tag + cost(enq_len, rr);
                end
            end else if (push_v[s] && qcnt[s] == '0) begin
                st_d.start[s]  = restart_tag;
                st_d.finish[s] = restart_tag + cost(enq_len, rr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_valid  = st_q.gv;
    assign grant_sess   = st_q.gs;
    assign grant_len    = st_q.gl;
    assign grant_start  = st_q.gst;
    assign grant_finish = st_q.gfi;
    assign sys_vtime    = st_q.vt;

endmodule

// File: rtl/pfq_sched_chk.sv
module pfq_sched_chk
    import pfq_pkg::*;
#(
    parameter int         NUM_SESS = 8,
    parameter int         TAG_W    = 32,
    parameter vt_mode_e   VT_MODE  = VT_MIN_HEAD_START,
    parameter pick_mode_e SEL_MODE = PICK_ELIGIBLE_FINISH
) (
    input logic                clk,
    input logic                rst_n,
    input logic                grant_valid,
    input logic [TAG_W-1:0]    grant_start,
    input logic [TAG_W-1:0]    grant_finish,
    input logic [TAG_W-1:0]    sys_vtime,
    input logic                link_busy,
    input logic                any_backlog,
    input logic [NUM_SESS-1:0] pop_v
);

    assert_grant_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        link_busy |=> !grant_valid);

    assert_one_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_v));

    assert_finish_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_finish >= grant_start);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_backlog |=> $stable(sys_vtime));

    if (VT_MODE == VT_MIN_HEAD_START) begin : g_mono
        assert_vt_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> sys_vtime >= $past(sys_vtime));
        if (SEL_MODE == PICK_ELIGIBLE_FINISH) begin : g_elig
            assert_grant_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
                grant_valid |-> grant_start <= sys_vtime);
        end
    end

endmodule

bind pfq_sched pfq_sched_chk #(
    .NUM_SESS (NUM_SESS),
    .TAG_W    (TAG_W),
    .VT_MODE  (VT_MODE),
    .SEL_MODE (SEL_MODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_valid  (grant_valid),
    .grant_start  (grant_start),
    .grant_finish (grant_finish),
    .sys_vtime    (sys_vtime),
    .link_busy    (link_busy),
    .any_backlog  (any_backlog),
    .pop_v        (pop_v)
);

// File: tb/pfq_sched_test.sv
module pfq_sched_test;
    import pfq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enq_valid = 1'b0;
    logic [2:0]   enq_sess = '0;
    logic [15:0]  enq_len = '0;
    logic [127:0] recip_rate;
    logic         tx_done = 1'b0;

    logic         grant_valid, a_valid;
    logic [2:0]   grant_sess, a_sess;
    logic [15:0]  grant_len, a_len;
    logic [31:0]  grant_start, grant_finish, sys_vtime;
    logic [31:0]  a_start, a_finish, a_vtime;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [2:0]  last_alt_sess;
    logic [31:0] last_alt_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfq_sched uut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_sess(enq_sess),
        .enq_len(enq_len), .recip_rate(recip_rate), .tx_done(tx_done),
        .grant_valid(grant_valid), .grant_sess(grant_sess), .grant_len(grant_len),
        .grant_start(grant_start), .grant_finish(grant_finish), .sys_vtime(sys_vtime)
    );

    pfq_sched #(.VT_MODE(VT_SERVED_START), .SEL_MODE(PICK_MIN_START)) uut_alt (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_sess(enq_sess),
        .enq_len(enq_len), .recip_rate(recip_rate), .tx_done(tx_done),
        .grant_valid(a_valid), .grant_sess(a_sess), .grant_len(a_len),
        .grant_start(a_start), .grant_finish(a_finish), .sys_vtime(a_vtime)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_all_recip(input logic [15:0] v);
        for (int s = 0; s < 8; s++) recip_rate[s*16 +: 16] = v;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; enq_valid = 1'b0; tx_done = 1'b0;
        set_all_recip(16'd256);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic enq(input int s, input int len);
        enq_valid = 1'b1; enq_sess = 3'(s); enq_len = 16'(len);
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic release_link();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic take_grant(input int s, input int len, input int st,
                              input int fi, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (grant_valid) begin
                seen = 1'b1;
                if (a_valid) begin
                    last_alt_sess  = a_sess;
                    last_alt_start = a_start;
                end
            end
        end
        chk(seen, req, "grant seen", 32'(seen), 32'd1);
        chk(grant_sess == 3'(s), req, "grant session", 32'(grant_sess), 32'(s));
        chk(grant_len == 16'(len), req, "grant length", 32'(grant_len), 32'(len));
        chk(grant_start == 32'(st), req, "start tag", grant_start, 32'(st));
        chk(grant_finish == 32'(fi), req, "finish tag", grant_finish, 32'(fi));
    endtask

    task automatic quiet(input int n, input string req);
        int hits = 0;
        repeat (n) begin
            @(negedge clk);
            if (grant_valid) hits++;
        end
        chk(hits == 0, req, "grants in quiet window", 32'(hits), 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(grant_valid == 1'b0, "R1", "grant after reset", 32'(grant_valid), 32'd0);
        chk(sys_vtime == 32'd0, "R1", "vtime after reset", sys_vtime, 32'd0);
        quiet(8, "R1");
    endtask

    task automatic t_busy_hold();
        do_reset();
        enq(0, 5);
        take_grant(0, 5, 0, 5, "R2");
        enq(1, 5);
        quiet(10, "R2");
        release_link();
        take_grant(1, 5, 0, 5, "R2");
        release_link();
    endtask

    task automatic t_order();
        do_reset();
        enq(0, 10);
        take_grant(0, 10, 0, 10, "R2");
        enq(1, 300);
        enq(2, 100);
        enq(2, 100);
        release_link();
        take_grant(2, 100, 0, 100, "R6");
        chk(last_alt_sess == 3'd1, "R10", "alt first pick", 32'(last_alt_sess), 32'd1);
        release_link();
        take_grant(1, 300, 0, 300, "R6");
        chk(last_alt_sess == 3'd2, "R10", "alt second pick", 32'(last_alt_sess), 32'd2);
        release_link();
        take_grant(2, 100, 100, 200, "R5");
        chk(last_alt_sess == 3'd2, "R10", "alt third pick", 32'(last_alt_sess), 32'd2);
        chk(last_alt_start == 32'd100, "R10", "alt third start", last_alt_start, 32'd100);
        chk(a_vtime == 32'd100, "R10", "alt vtime", a_vtime, 32'd100);
        release_link();
        chk(sys_vtime == 32'd100, "R8", "vtime after drain", sys_vtime, 32'd100);
        quiet(5, "R8");
        chk(sys_vtime == 32'd100, "R8", "vtime held while empty", sys_vtime, 32'd100);
    endtask

    task automatic t_tie();
        do_reset();
        enq(5, 10);
        take_grant(5, 10, 0, 10, "R2");
        enq(3, 50);
        enq(1, 50);
        release_link();
        take_grant(1, 50, 0, 50, "R7");
        release_link();
        take_grant(3, 50, 0, 50, "R7");
        release_link();
    endtask

    task automatic t_rate();
        do_reset();
        recip_rate[1*16 +: 16] = 16'd512;
        enq(7, 10);
        take_grant(7, 10, 0, 10, "R3");
        enq(1, 40);
        enq(0, 60);
        release_link();
        take_grant(0, 60, 0, 60, "R6");
        release_link();
        take_grant(1, 40, 0, 80, "R3");
        release_link();
    endtask

    task automatic t_restart();
        do_reset();
        enq(0, 100);
        take_grant(0, 100, 0, 100, "R4");
        release_link();
        enq(0, 10);
        take_grant(0, 10, 100, 110, "R4");
        chk(sys_vtime == 32'd100, "R8", "vtime follows head start", sys_vtime, 32'd100);
        release_link();
        enq(1, 10);
        take_grant(1, 10, 100, 110, "R4");
        release_link();
    endtask

    task automatic t_full();
        do_reset();
        enq(4, 10);
        take_grant(4, 10, 0, 10, "R9");
        for (int i = 1; i <= 17; i++) enq(6, i);
        release_link();
        for (int i = 1; i <= 16; i++) begin
            take_grant(6, i, (i - 1) * i / 2, i * (i + 1) / 2, "R9");
            release_link();
        end
        quiet(10, "R9");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        set_all_recip(16'd256);
        last_alt_sess = '0;
        last_alt_start = '0;
        @(negedge clk);
        t_reset();
        t_busy_hold();
        t_order();
        t_tie();
        t_rate();
        t_restart();
        t_full();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule